// File: doc/BRIEF.md
# Fuzzy Inference Engine

This block runs a Mamdani-style fuzzy inference whose consequents are crisp singletons. A sequencer outside the block hands it one command at a time. Each command is an opcode plus operands. The block keeps eight byte-wide fuzzy input registers, which are filled through a separate load port. It also keeps a small set of 4-bit truth registers: two operand slots, a last-result register K and a bracket-save register M.

Membership functions are triangles of height 15. Their shape parameters are fetched byte by byte from an external parameter memory. Alpha values are combined with min (AND) and max (OR). Each rule's crisp value is weighted by the rule's final truth value and added into running sums. An output command returns the weighted average as one byte, together with a destination index and a one-cycle done pulse.

Membership slopes and the final average both go through a single shared restoring divider. Commands that take more than one cycle hold `cmd_ready` low until they finish.

Top module: `fuzzy_infer_engine`

## Requirements
- R1: After synchronous reset, `cmd_ready` is 1 and `res_done` is 0. All truth registers, both sums and all input registers are 0, so an OUT issued first returns 0.
- R2: Function m occupies parameter bytes 3m (left semi-base L), 3m+1 (vertex V) and 3m+2 (right semi-base R). `pmem_data` returns the byte at the address presented on the previous clock.
- R3: LDP (opcode 1) on input x and function m yields t = floor(|V−x|·15 / S). S is L when x<V and R when x>V. The alpha is 15−t, or 0 when t≥15.
- R4: The alpha is 15 whenever x equals V, whatever the semi-base lengths. The alpha is 0 when x lies on a side whose semi-base length is 0.
- R5: LDN (opcode 2) yields 15 minus the alpha that LDP would give for the same operands.
- R6: A load (LDP, LDN, LDK, LDM) moves the newer operand slot into the older slot, then writes the value into the newer slot and into K. FZAND (opcode 3) sets K to the minimum of the two slots. FZOR (opcode 4) sets K to the maximum.
- R7: LDK (opcode 5) loads K as an operand. SKM (opcode 6) copies K into M. LDM (opcode 7) loads M as an operand, which makes bracketed sub-expressions possible.
- R8: CON (opcode 8) with crisp value c adds c·K to the numerator sum and adds K to the weight sum.
- R9: OUT (opcode 9) with destination n raises `res_done` for one cycle, with `res_data` = floor(numerator / weight sum) and `res_dest` = n. It then clears both sums.
- R10: OUT with a weight sum of 0 returns `res_data` = 0.
- R11: When `in_we` is 1, `in_data` is written into input register `in_sel` at the clock edge. LDP and LDN read that register.
- R12: LDP, LDN and an OUT with a nonzero weight sum drop `cmd_ready` until they complete. A command presented while `cmd_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_we | input | 1 | Input register write strobe |
| in_sel | input | 3 | Input register index |
| in_data | input | 8 | Input register write value |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 4 | Opcode |
| cmd_inp | input | 3 | Input register selector for LDP/LDN |
| cmd_idx | input | 9 | Membership function number for LDP/LDN |
| cmd_crisp | input | 8 | Crisp value for CON |
| cmd_dest | input | 8 | Destination index for OUT |
| pmem_addr | output | 10 | Parameter memory byte address |
| pmem_data | input | 8 | Parameter memory read data, one cycle after address |
| res_done | output | 1 | One-cycle result strobe |
| res_data | output | 8 | Defuzzified result |
| res_dest | output | 8 | Destination index of the result |

## Verification
Membership evaluation is exercised with inputs below the vertex, above the vertex and exactly at the vertex. It is also exercised far outside the triangle and against a zero-length side. These cases separate the two slope branches, the vertex override and the zero-clamp. Functions at index 0 and at a high index check the three-byte address scaling.

The operator sequences cover plain AND, a chained AND-then-OR, and a bracketed form that uses SKM and LDM. These show that the two-slot operand window and the K/M registers combine the right values.

Single-rule, multi-rule, empty and zero-weight outputs separate the divider path from the zero-sum path and show that the sums are cleared. A command pushed in while the block is busy shows that it has no effect.

// File: rtl/fz_pkg.sv
package fz_pkg;

    localparam int ALPHA_W   = 4;
    localparam int ALPHA_MAX = 15;
    localparam int BYTE_W    = 8;

    typedef logic [ALPHA_W-1:0] alpha_t;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_LDP = 4'd1,
        OP_LDN = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_LDK = 4'd5,
        OP_SKM = 4'd6,
        OP_LDM = 4'd7,
        OP_CON = 4'd8,
        OP_OUT = 4'd9
    } fz_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_L,
        ST_FETCH_V,
        ST_FETCH_R,
        ST_EVAL,
        ST_DIV_ALPHA,
        ST_DIV_OUT
    } fz_state_e;

    // Two of the three shape bytes, held while the third is read.
    typedef struct packed {
        logic [BYTE_W-1:0] lvd;
        logic [BYTE_W-1:0] vtx;
    } mbf_part_t;

    // Control word for the truth-value register file.
    typedef struct packed {
        logic   push;
        alpha_t push_val;
        logic   comb;
        logic   comb_or;
        logic   save;
    } opnd_ctl_t;

    // Convert scaled distance steps into a membership degree.
    function automatic alpha_t alpha_from_steps(input logic [31:0] steps);
        if (steps >= 32'(ALPHA_MAX)) return '0;
        return alpha_t'(32'(ALPHA_MAX) - steps);
    endfunction

    function automatic alpha_t alpha_invert(input alpha_t a);
        return alpha_t'(ALPHA_MAX) - a;
    endfunction

endpackage

// File: rtl/fz_seq_div.sv
// Restoring divider: one quotient bit per cycle, MSB first.
module fz_seq_div #(
    parameter  int NW = 24,
    parameter  int DW = 16,
    localparam int CW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quot
);

    logic [DW-1:0] rem_q;
    logic [DW-1:0] den_q;
    logic [NW-1:0] qr_q;
    logic [CW-1:0] cnt_q;
    logic [DW:0]   rem_sh;
    logic          fits;

    assign rem_sh = {rem_q, qr_q[NW-1]};
    assign fits   = rem_sh >= {1'b0, den_q};
    assign quot   = qr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            den_q <= '0;
            qr_q  <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                den_q <= den;
                qr_q  <= num;
                cnt_q <= CW'(NW);
            end else if (cnt_q != '0) begin
                qr_q  <= {qr_q[NW-2:0], fits};
                rem_q <= fits ? DW'(rem_sh - {1'b0, den_q}) : rem_sh[DW-1:0];
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fz_operand_regs.sv
// Truth-value registers: two operand slots, last result K, save register M.
module fz_operand_regs
    import fz_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  opnd_ctl_t ctl,
    output alpha_t    slot_old,
    output alpha_t    slot_new,
    output alpha_t    k_val,
    output alpha_t    m_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_old <= '0;
            slot_new <= '0;
            k_val    <= '0;
            m_val    <= '0;
        end else begin
            if (ctl.push) begin
                slot_old <= slot_new;
                slot_new <= ctl.push_val;
                k_val    <= ctl.push_val;
            end else if (ctl.comb) begin
                if (ctl.comb_or)
                    k_val <= (slot_old > slot_new) ? slot_old : slot_new;
                else
                    k_val <= (slot_old < slot_new) ? slot_old : slot_new;
            end
            if (ctl.save) m_val <= k_val;
        end
    end

endmodule

// File: rtl/fz_accum.sv
// Weighted-sum and weight-sum accumulators for defuzzification.
module fz_accum
    import fz_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int DEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add,
    input  logic [BYTE_W-1:0] crisp,
    input  alpha_t            weight,
    output logic [ACC_W-1:0]  num,
    output logic [DEN_W-1:0]  den
);

    localparam int PROD_W = BYTE_W + ALPHA_W;

    logic [PROD_W-1:0] prod;

    assign prod = {{ALPHA_W{1'b0}}, crisp} * {{BYTE_W{1'b0}}, weight};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            num <= '0;
            den <= '0;
        end else if (add) begin
            num <= num + ACC_W'(prod);
            den <= den + DEN_W'(weight);
        end
    end

endmodule

// File: rtl/fuzzy_infer_engine.sv
module fuzzy_infer_engine
    import fz_pkg::*;
#(
    parameter  int NUM_IN  = 8,
    parameter  int PMEM_AW = 10,
    parameter  int IDX_W   = 9,
    parameter  int ACC_W   = 24,
    parameter  int DEN_W   = 16,
    parameter  int DEST_W  = 8,
    localparam int SEL_W   = $clog2(NUM_IN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_we,
    input  logic [SEL_W-1:0]   in_sel,
    input  logic [7:0]         in_data,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [3:0]         cmd_op,
    input  logic [SEL_W-1:0]   cmd_inp,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [7:0]         cmd_crisp,
    input  logic [DEST_W-1:0]  cmd_dest,
    output logic [PMEM_AW-1:0] pmem_addr,
    input  logic [7:0]         pmem_data,
    output logic               res_done,
    output logic [7:0]         res_data,
    output logic [DEST_W-1:0]  res_dest
);

    localparam int MUL_W   = IDX_W + 2;
    localparam int SCALE_W = BYTE_W + ALPHA_W;

    fz_state_e         state_q;
    logic [PMEM_AW-1:0] base_q;
    logic [SEL_W-1:0]  sel_q;
    logic              neg_q;
    mbf_part_t         part_q;
    logic [BYTE_W-1:0] in_regs [NUM_IN];

    fz_op_e    op;
    logic      fire;
    opnd_ctl_t ctl;
    alpha_t    slot_old, slot_new, k_val, m_val;

    logic              acc_clr, acc_add;
    logic [ACC_W-1:0]  acc_num;
    logic [DEN_W-1:0]  acc_den;

    logic              div_start, div_done;
    logic [ACC_W-1:0]  div_num, div_quot;
    logic [DEN_W-1:0]  div_den;

    // Membership evaluation terms
    logic [BYTE_W-1:0]  x_val, diff, semi;
    logic               below, at_vertex, need_div;
    logic [SCALE_W-1:0] scaled;
    alpha_t             direct_alpha, div_alpha;

    assign op        = fz_op_e'(cmd_op);
    assign cmd_ready = (state_q == ST_IDLE);
    assign fire      = cmd_valid && cmd_ready;

    assign x_val        = in_regs[sel_q];
    assign below        = x_val < part_q.vtx;
    assign at_vertex    = x_val == part_q.vtx;
    assign diff         = below ? (part_q.vtx - x_val) : (x_val - part_q.vtx);
    assign semi         = below ? part_q.lvd : pmem_data;
    assign scaled       = {{ALPHA_W{1'b0}}, diff} * SCALE_W'(ALPHA_MAX);
    assign need_div     = !at_vertex && (semi != '0);
    assign direct_alpha = at_vertex ? alpha_t'(ALPHA_MAX) : '0;
    assign div_alpha    = alpha_from_steps(32'(div_quot));

    always_comb begin
        case (state_q)
            ST_FETCH_V: pmem_addr = base_q + PMEM_AW'(1);
            ST_FETCH_R: pmem_addr = base_q + PMEM_AW'(2);
            default:    pmem_addr = base_q;
        endcase
    end

    always_comb begin
        ctl       = '0;
        acc_add   = 1'b0;
        acc_clr   = 1'b0;
        div_start = 1'b0;
        div_num   = acc_num;
        div_den   = acc_den;
        case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    case (op)
                        OP_AND: ctl.comb = 1'b1;
                        OP_OR: begin
                            ctl.comb    = 1'b1;
                            ctl.comb_or = 1'b1;
                        end
                        OP_LDK: begin
                            ctl.push     = 1'b1;
                            ctl.push_val = k_val;
                        end
                        OP_SKM: ctl.save = 1'b1;
                        OP_LDM: begin
                            ctl.push     = 1'b1;
                            ctl.push_val = m_val;
                        end
                        OP_CON: acc_add = 1'b1;
                        OP_OUT: begin
                            acc_clr   = 1'b1;
                            div_start = (acc_den != '0);
                        end
                        default: ;
                    endcase
                end
            end
            ST_EVAL: begin
                if (need_div) begin
                    div_start = 1'b1;
                    div_num   = ACC_W'(scaled);
                    div_den   = DEN_W'(semi);
                end else begin
                    ctl.push     = 1'b1;
                    ctl.push_val = neg_q ? alpha_invert(direct_alpha) : direct_alpha;
                end
            end
            ST_DIV_ALPHA: begin
                if (div_done) begin
                    ctl.push     = 1'b1;
                    ctl.push_val = neg_q ? alpha_invert(div_alpha) : div_alpha;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            base_q   <= '0;
            sel_q    <= '0;
            neg_q    <= 1'b0;
            part_q   <= '0;
            res_done <= 1'b0;
            res_data <= '0;
            res_dest <= '0;
            for (int i = 0; i < NUM_IN; i++) in_regs[i] <= '0;
        end else begin
            res_done <= 1'b0;
            if (in_we) in_regs[in_sel] <= in_data;
            case (state_q)
                ST_IDLE: begin
                    if (fire) begin
                        case (op)
                            OP_LDP, OP_LDN: begin
                                base_q  <= PMEM_AW'(MUL_W'(cmd_idx) * MUL_W'(3));
                                sel_q   <= cmd_inp;
                                neg_q   <= (op == OP_LDN);
                                state_q <= ST_FETCH_L;
                            end
                            OP_OUT: begin
                                res_dest <= cmd_dest;
                                if (acc_den == '0) begin
                                    res_done <= 1'b1;
                                    res_data <= '0;
                                end else begin
                                    state_q <= ST_DIV_OUT;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_FETCH_L: state_q <= ST_FETCH_V;
                ST_FETCH_V: begin
                    part_q.lvd <= pmem_data;
                    state_q    <= ST_FETCH_R;
                end
                ST_FETCH_R: begin
                    part_q.vtx <= pmem_data;
                    state_q    <= ST_EVAL;
                end
                ST_EVAL: state_q <= need_div ? ST_DIV_ALPHA : ST_IDLE;
                ST_DIV_ALPHA: if (div_done) state_q <= ST_IDLE;
                ST_DIV_OUT: begin
                    if (div_done) begin
                        res_done <= 1'b1;
                        res_data <= div_quot[7:0];
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    fz_operand_regs u_opnd (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .slot_old (slot_old),
        .slot_new (slot_new),
        .k_val    (k_val),
        .m_val    (m_val)
    );

    fz_accum #(.ACC_W(ACC_W), .DEN_W(DEN_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (acc_clr),
        .add    (acc_add),
        .crisp  (cmd_crisp),
        .weight (k_val),
        .num    (acc_num),
        .den    (acc_den)
    );

    fz_seq_div #(.NW(ACC_W), .DW(DEN_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quot  (div_quot)
    );

endmodule

// File: rtl/fz_checker.sv
module fz_checker
    import fz_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int DEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [3:0]       cmd_op,
    input logic             res_done,
    input alpha_t           slot_old,
    input alpha_t           slot_new,
    input alpha_t           k_val,
    input logic [ACC_W-1:0] acc_num,
    input logic [DEN_W-1:0] acc_den
);

    logic fire;
    assign fire = cmd_valid && cmd_ready;

    assert_and_min_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_op == OP_AND) |=>
            k_val == (($past(slot_old) < $past(slot_new)) ? $past(slot_old) : $past(slot_new)));

    assert_or_max_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_op == OP_OR) |=>
            k_val == (($past(slot_old) > $past(slot_new)) ? $past(slot_old) : $past(slot_new)));

    assert_weight_sum_R8: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_op == OP_CON) |=>
            acc_den == $past(acc_den) + DEN_W'($past(k_val)));

    assert_sums_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_op == OP_OUT) |=> (acc_num == '0 && acc_den == '0));

    assert_busy_on_eval_R12: assert property (@(posedge clk) disable iff (rst)
        (fire && (cmd_op == OP_LDP || cmd_op == OP_LDN)) |=> !cmd_ready);

    assert_done_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
        res_done |-> cmd_ready);

endmodule

bind fuzzy_infer_engine fz_checker #(.ACC_W(ACC_W), .DEN_W(DEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .res_done  (res_done),
    .slot_old  (slot_old),
    .slot_new  (slot_new),
    .k_val     (k_val),
    .acc_num   (acc_num),
    .acc_den   (acc_den)
);

// File: tb/tb_fuzzy_infer_engine.sv
module tb_fuzzy_infer_engine;

    localparam int CLK_PERIOD = 10;
    localparam int OP_LDP = 1, OP_LDN = 2, OP_AND = 3, OP_OR = 4, OP_LDK = 5;
    localparam int OP_SKM = 6, OP_LDM = 7, OP_CON = 8, OP_OUT = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_we = 1'b0;
    logic [2:0] in_sel = '0;
    logic [7:0] in_data = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [3:0] cmd_op = '0;
    logic [2:0] cmd_inp = '0;
    logic [8:0] cmd_idx = '0;
    logic [7:0] cmd_crisp = '0;
    logic [7:0] cmd_dest = '0;
    logic [9:0] pmem_addr;
    logic [7:0] pmem_data = '0;
    logic       res_done;
    logic [7:0] res_data;
    logic [7:0] res_dest;

    logic [7:0] pmem [1024];

    int tests = 0;
    int fails = 0;

    // Reference model state
    int m_in [8];
    int m_a = 0, m_b = 0, m_k = 0, m_m = 0, m_num = 0, m_den = 0;
    int    exp_data_q [$];
    int    exp_dest_q [$];
    string tag_q [$];

    fuzzy_infer_engine dut (
        .clk(clk), .rst(rst), .in_we(in_we), .in_sel(in_sel), .in_data(in_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_inp(cmd_inp), .cmd_idx(cmd_idx), .cmd_crisp(cmd_crisp),
        .cmd_dest(cmd_dest), .pmem_addr(pmem_addr), .pmem_data(pmem_data),
        .res_done(res_done), .res_data(res_data), .res_dest(res_dest)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) pmem_data <= pmem[pmem_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Compare every clock: a result strobe must match the next queued expectation.
    always @(negedge clk) begin
        if (!rst && res_done) begin
            tests++;
            if (exp_data_q.size() == 0) begin
                fails++;
                $display("FAIL R9: actual unexpected result %0d expected no result", res_data);
            end else begin
                automatic int    ed = exp_data_q.pop_front();
                automatic int    en = exp_dest_q.pop_front();
                automatic string tg = tag_q.pop_front();
                if (res_data != 8'(ed) || res_dest != 8'(en)) begin
                    fails++;
                    $display("FAIL %s: actual data %0d dest %0d expected data %0d dest %0d",
                             tg, res_data, res_dest, ed, en);
                end
            end
        end
    end

    function automatic int ref_alpha(input int x, input int idx);
        int l, v, r, t;
        l = pmem[3 * idx];
        v = pmem[3 * idx + 1];
        r = pmem[3 * idx + 2];
        if (x == v) return 15;
        if (x < v) begin
            if (l == 0) return 0;
            t = ((v - x) * 15) / l;
        end else begin
            if (r == 0) return 0;
            t = ((x - v) * 15) / r;
        end
        return (t >= 15) ? 0 : 15 - t;
    endfunction

    task automatic wait_ready();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic issue(input int op, input int inp, input int idx, input int crisp, input int dest);
        wait_ready();
        cmd_valid = 1'b1;
        cmd_op    = 4'(op);
        cmd_inp   = 3'(inp);
        cmd_idx   = 9'(idx);
        cmd_crisp = 8'(crisp);
        cmd_dest  = 8'(dest);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push(input int v);
        m_a = m_b;
        m_b = v;
        m_k = v;
    endtask

    task automatic load_in(input int i, input int v);
        wait_ready();
        in_we   = 1'b1;
        in_sel  = 3'(i);
        in_data = 8'(v);
        @(negedge clk);
        in_we   = 1'b0;
        m_in[i] = v;
    endtask

    task automatic ldp(input int n, input int m);
        issue(OP_LDP, n, m, 0, 0);
        push(ref_alpha(m_in[n], m));
    endtask

    task automatic ldn(input int n, input int m);
        issue(OP_LDN, n, m, 0, 0);
        push(15 - ref_alpha(m_in[n], m));
    endtask

    task automatic fzand();
        issue(OP_AND, 0, 0, 0, 0);
        m_k = (m_a < m_b) ? m_a : m_b;
    endtask

    task automatic fzor();
        issue(OP_OR, 0, 0, 0, 0);
        m_k = (m_a > m_b) ? m_a : m_b;
    endtask

    task automatic ldk();
        issue(OP_LDK, 0, 0, 0, 0);
        push(m_k);
    endtask

    task automatic skm();
        issue(OP_SKM, 0, 0, 0, 0);
        m_m = m_k;
    endtask

    task automatic ldm();
        issue(OP_LDM, 0, 0, 0, 0);
        push(m_m);
    endtask

    task automatic con(input int c);
        issue(OP_CON, 0, 0, c, 0);
        m_num += c * m_k;
        m_den += m_k;
    endtask

    task automatic out(input int dest, input string tag);
        issue(OP_OUT, 0, 0, 0, dest);
        exp_data_q.push_back((m_den == 0) ? 0 : m_num / m_den);
        exp_dest_q.push_back(dest);
        tag_q.push_back(tag);
        m_num = 0;
        m_den = 0;
        wait_ready();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R12: actual run hung expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) pmem[i] = 8'd0;
        for (int i = 0; i < 8; i++) m_in[i] = 0;
        // function 0: L=40 V=100 R=60
        pmem[0] = 8'd40;  pmem[1] = 8'd100; pmem[2] = 8'd60;
        // function 1: L=0 V=50 R=20
        pmem[3] = 8'd0;   pmem[4] = 8'd50;  pmem[5] = 8'd20;
        // function 2: L=30 V=200 R=0
        pmem[6] = 8'd30;  pmem[7] = 8'd200; pmem[8] = 8'd0;
        // function 300 at byte 900: L=10 V=128 R=10
        pmem[900] = 8'd10; pmem[901] = 8'd128; pmem[902] = 8'd10;

        repeat (3) @(negedge clk);
        check(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1);
        check(res_done == 1'b0, "R1", int'(res_done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1);

        // R1 / R10: first output with nothing accumulated
        out(5, "R1");

        load_in(0, 80);  load_in(1, 130); load_in(2, 100); load_in(3, 10);
        load_in(4, 250); load_in(5, 128); load_in(6, 50);  load_in(7, 120);

        // R3 left side, R11 loaded value used
        ldp(0, 0); con(255); ldp(2, 0); con(0); out(1, "R3");
        // R3 right side
        ldp(1, 0); con(255); ldp(2, 0); con(0); out(2, "R3");
        // R4 zero left semi-base, then exact vertex
        ldp(3, 1); con(255); ldp(6, 1); con(40); out(3, "R4");
        // R4 zero right semi-base on function 2
        ldp(4, 2); con(200); ldp(2, 0); con(90); out(4, "R4");
        // R3 clamp far outside triangle
        ldp(4, 0); con(200); ldp(2, 0); con(100); out(6, "R3");
        // R5 complement
        ldn(0, 0); con(255); ldp(2, 0); con(0); out(7, "R5");
        // R2 high function index
        ldp(5, 300); con(77); ldp(7, 300); con(200); out(8, "R2");
        // R6 AND of two loads
        ldn(0, 0); ldp(1, 0); fzand(); con(255); ldp(2, 0); con(0); out(9, "R6");
        // R6 / R7 chained: (NOT a AND b) OR c via LDK
        ldn(1, 0); ldp(7, 300); fzand(); ldk(); ldp(0, 0); fzor(); con(180);
        ldp(3, 1); con(20); out(10, "R7");
        // R7 bracketed form with SKM and LDM
        ldp(0, 0); ldn(1, 0); fzand(); skm(); ldp(7, 300); ldn(5, 300); fzor();
        ldk(); ldm(); fzor(); con(230); ldp(2, 0); con(10); out(11, "R7");
        // R8 three weighted rules
        ldp(0, 0); con(30); ldp(1, 0); con(150); ldp(7, 300); con(250); out(12, "R8");
        // R10 only zero-weight rules
        ldp(4, 0); con(123); out(13, "R10");
        // R11 reload an input and reuse it
        load_in(0, 96); ldp(0, 0); con(255); ldp(2, 0); con(0); out(14, "R11");

        // R12 command while busy is ignored
        ldp(2, 0);
        check(cmd_ready == 1'b0, "R12", int'(cmd_ready), 0);
        cmd_valid = 1'b1; cmd_op = 4'(OP_CON); cmd_crisp = 8'd255;
        @(negedge clk);
        cmd_valid = 1'b0;
        con(10); out(15, "R12");

        // R9 sums cleared: a fresh single rule returns its own crisp value
        ldp(2, 0); con(61); out(16, "R9");

        repeat (5) @(negedge clk);
        check(exp_data_q.size() == 0, "R9", exp_data_q.size(), 0);
        summary();
        $finish;
    end

endmodule